// File: doc/BRIEF.md
# Power-Fail Write-Protect Controller

This block shields a byte-wide static memory from corruption while its main supply collapses and later returns. Two synchronous comparator flags tell it whether the supply sits below the power-fail threshold and whether it has dropped further, below the battery switchover threshold. It watches the memory's chip-enable, write-enable and output-enable strobes from the host. It passes gated copies of the two control strobes to the memory, and it drives the enable for the memory's tri-state data outputs.

A host cycle that is already running when the supply fails is given a bounded grace window to finish. Once the window closes or the cycle ends, every host strobe is blocked. Protection stays in force until the supply has been good for a fixed stabilization window. All windows are counted in clock cycles and set by parameters. A separate output selects the battery while the supply is below the switchover threshold.

Top module: `pfwp_ctrl`

## Requirements
- R1: While reset is asserted, and for TCER clock cycles after it is released with the supply good, `wp` is 1 and `status` is 2'b11 (recovering). After that the block enters normal operation: `wp` is 0 and `status` is 2'b00.
- R2: In normal operation, if `pf_low` is sampled high while `ce_n` is high, `wp` is 1 and `status` is 2'b10 (protected) after that clock edge.
- R3: In normal operation, if `pf_low` is sampled high while `ce_n` is low, the block enters grace (`status` 2'b01). `wp` stays 0 and the host strobes still pass through. The first edge at which `ce_n` is sampled high ends grace, and the block is protected after that edge.
- R4: Grace lasts at most TWPT clock edges. If `ce_n` stays low, `wp` is 1 after edge TWPT+1, counted from the edge that first sampled `pf_low` high.
- R5: While `wp` is 1, `dq_oe` is 0 and `mem_ce_n` and `mem_we_n` are 1, whatever `ce_n`, `we_n` and `oe_n` do.
- R6: While `wp` is 0, `mem_ce_n` equals `ce_n` and `mem_we_n` equals `we_n`. `dq_oe` is 1 exactly when `ce_n` is 0, `oe_n` is 0 and `we_n` is 1.
- R7: `bat_sel` equals the value `so_low` had at the previous clock edge, and it is 0 in reset.
- R8: From protected, the first edge that samples `pf_low` low moves the block to recovering (`status` 2'b11). `wp` is released only after TCER further edges with `pf_low` low.
- R9: If `pf_low` is sampled high during recovery, the block returns to protected. A later recovery then needs a full TCER-cycle window again.
- R10: A grace window that has started runs to its end even if `pf_low` clears during it. The block then passes through protected and a full recovery window before it releases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_low | input | 1 | Supply below power-fail threshold |
| so_low | input | 1 | Supply below battery switchover threshold |
| ce_n | input | 1 | Host chip-enable, active low |
| we_n | input | 1 | Host write-enable, active low |
| oe_n | input | 1 | Host output-enable, active low |
| wp | output | 1 | Deselect / write-protect |
| mem_ce_n | output | 1 | Gated chip-enable to memory |
| mem_we_n | output | 1 | Gated write-enable to memory |
| dq_oe | output | 1 | Data output tri-state enable |
| bat_sel | output | 1 | Battery select |
| status | output | 2 | 00 normal, 01 grace, 10 protected, 11 recovering |

## Verification
Some properties are checked by assertions on every cycle:
- Strobe blocking and output disable whenever `wp` is set.
- The one-cycle delay of `bat_sel`.
- The immediate lock when power fails with no access under way.
- The upper bound on grace length.
- The rule that every release is preceded by at least TCER good-supply cycles.
- The fall-back from recovering to protected.

Other behaviour can only be shown by the bench's scenarios. These are the exact release cycle after reset and after each outage, the point where grace ends for every possible access length, the full pass-through table in normal operation, grace running on after the supply has come back, and the restart of recovery after a second dip.

// File: rtl/pfwp_ctrl.sv
module pfwp_ctrl #(
  parameter int TWPT = 8,
  parameter int TCER = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pf_low,
  input  logic       so_low,
  input  logic       ce_n,
  input  logic       we_n,
  input  logic       oe_n,
  output logic       wp,
  output logic       mem_ce_n,
  output logic       mem_we_n,
  output logic       dq_oe,
  output logic       bat_sel,
  output logic [1:0] status
);
  localparam int MAXW = (TWPT > TCER) ? TWPT : TCER;
  localparam int CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] GRACE_LAST = CW'(TWPT - 1);
  localparam logic [CW-1:0] RECOV_LAST = CW'(TCER - 1);

  typedef enum logic [1:0] {
    ST_RUN   = 2'b00,
    ST_GRACE = 2'b01,
    ST_LOCK  = 2'b10,
    ST_RECOV = 2'b11
  } st_t;

  st_t          st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_RECOV;
      cnt <= '0;
    end else begin
      case (st)
        ST_RUN:
          if (pf_low) begin
            st  <= ce_n ? ST_LOCK : ST_GRACE;
            cnt <= '0;
          end
        ST_GRACE:
          if (ce_n || cnt == GRACE_LAST) st <= ST_LOCK;
          else                           cnt <= cnt + 1'b1;
        ST_LOCK:
          if (!pf_low) begin
            st  <= ST_RECOV;
            cnt <= '0;
          end
        default:
          if (pf_low)                 st <= ST_LOCK;
          else if (cnt == RECOV_LAST) st <= ST_RUN;
          else                        cnt <= cnt + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bat_sel <= 1'b0;
    else        bat_sel <= so_low;
  end

  assign status   = st;
  assign wp       = st[1];
  assign mem_ce_n = ce_n | wp;
  assign mem_we_n = we_n | wp;
  assign dq_oe    = ~wp & ~ce_n & ~oe_n & we_n;
endmodule

module pfwp_ctrl_chk #(
  parameter int TWPT = 8,
  parameter int TCER = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pf_low,
  input logic       so_low,
  input logic       ce_n,
  input logic       wp,
  input logic       mem_ce_n,
  input logic       mem_we_n,
  input logic       dq_oe,
  input logic       bat_sel,
  input logic [1:0] status
);
  int grace_run;
  int good_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grace_run <= 0;
      good_run  <= 0;
    end else begin
      grace_run <= (status == 2'b01) ? grace_run + 1 : 0;
      good_run  <= (wp && !pf_low) ? good_run + 1 : 0;
    end
  end

  // R5
  lock_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp |-> (!dq_oe && mem_ce_n && mem_we_n));

  // R2
  idle_fail_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b00 && pf_low && ce_n) |=> (wp && status == 2'b10));

  // R3
  grace_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b01) |-> !wp);

  // R4
  grace_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b01) |-> (grace_run < TWPT));

  // R7
  bat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (bat_sel == $past(so_low)));

  // R8
  release_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wp) |-> (good_run >= TCER));

  // R9
  recov_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b11 && pf_low) |=> (status == 2'b10));
endmodule

bind pfwp_ctrl pfwp_ctrl_chk #(.TWPT(TWPT), .TCER(TCER)) u_chk (
  .clk(clk), .rst_n(rst_n), .pf_low(pf_low), .so_low(so_low), .ce_n(ce_n),
  .wp(wp), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .dq_oe(dq_oe),
  .bat_sel(bat_sel), .status(status)
);

// File: tb/pfwp_ctrl_tb.sv
module pfwp_ctrl_tb;
  localparam int TWPT = 3;
  localparam int TCER = 5;

  logic clk = 1'b0;
  logic rst_n, pf_low, so_low, ce_n, we_n, oe_n;
  logic wp, mem_ce_n, mem_we_n, dq_oe, bat_sel;
  logic [1:0] status;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pfwp_ctrl #(.TWPT(TWPT), .TCER(TCER)) u_dut (
    .clk(clk), .rst_n(rst_n), .pf_low(pf_low), .so_low(so_low),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .wp(wp), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .dq_oe(dq_oe), .bat_sel(bat_sel), .status(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic recover_from_lock(input string req);
    pf_low = 1'b0;
    ce_n = 1'b1;
    for (int n = 1; n <= TCER + 1; n++) begin
      tick();
      chk(wp == (n <= TCER), req, wp, n <= TCER);
      chk(status == ((n <= TCER) ? 2'b11 : 2'b00), req, status, (n <= TCER) ? 3 : 0);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pf_low = 1'b0; so_low = 1'b1;
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state and R5 blocking during reset
    chk(wp == 1'b1 && status == 2'b11, "R1", status, 3);
    chk(!dq_oe && mem_ce_n && mem_we_n, "R5", {dq_oe, mem_ce_n, mem_we_n}, 3);
    chk(bat_sel == 1'b0, "R7", bat_sel, 0);
    so_low = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    for (int n = 1; n <= TCER; n++) begin
      tick();
      chk(wp == (n < TCER), "R1", wp, n < TCER);
    end
    chk(status == 2'b00, "R1", status, 0);

    // R6 full pass-through table
    for (int v = 0; v < 8; v++) begin
      {ce_n, we_n, oe_n} = 3'(v);
      #1;
      chk(mem_ce_n == ce_n && mem_we_n == we_n, "R6", {mem_ce_n, mem_we_n}, {ce_n, we_n});
      chk(dq_oe == (!ce_n && !oe_n && we_n), "R6", dq_oe, !ce_n && !oe_n && we_n);
    end

    // R7 battery select follows with one cycle delay
    for (int v = 0; v < 4; v++) begin
      so_low = v[0];
      tick();
      chk(bat_sel == v[0], "R7", bat_sel, v[0]);
    end
    so_low = 1'b0;
    tick();

    // R2 R3 R4 grace sweep over every access length
    for (int j = 0; j <= TWPT + 2; j++) begin
      int e;
      e = (j == 0) ? 1 : (((j + 1) < (TWPT + 1)) ? (j + 1) : (TWPT + 1));
      we_n = 1'b1; oe_n = 1'b0; pf_low = 1'b1;
      for (int n = 1; n <= TWPT + 2; n++) begin
        ce_n = ((n - 1) >= j);
        tick();
        chk(wp == (n >= e), (j == 0) ? "R2" : ((j >= TWPT) ? "R4" : "R3"), wp, n >= e);
        if (n < e) begin
          chk(status == 2'b01 && dq_oe, "R3", {status, dq_oe}, 3);
        end else begin
          chk(status == 2'b10, "R2", status, 2);
        end
      end
      // R5 all host strobe patterns ignored while protected
      for (int v = 0; v < 8; v++) begin
        {ce_n, we_n, oe_n} = 3'(v);
        tick();
        chk(!dq_oe && mem_ce_n && mem_we_n && status == 2'b10, "R5",
            {dq_oe, mem_ce_n, mem_we_n}, 3);
      end
      recover_from_lock("R8");
    end

    // R10 supply returns during grace
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; pf_low = 1'b1;
    tick();
    chk(status == 2'b01, "R10", status, 1);
    pf_low = 1'b0;
    for (int n = 2; n <= TWPT + TCER + 3; n++) begin
      tick();
      chk(wp == (n >= TWPT + 1 && n < TWPT + 2 + TCER), "R10", wp,
          n >= TWPT + 1 && n < TWPT + 2 + TCER);
    end
    chk(status == 2'b00, "R10", status, 0);

    // R9 dip during recovery restarts the window
    ce_n = 1'b1; pf_low = 1'b1;
    tick();
    chk(status == 2'b10, "R9", status, 2);
    pf_low = 1'b0;
    tick();
    tick();
    chk(status == 2'b11, "R9", status, 3);
    pf_low = 1'b1;
    tick();
    chk(status == 2'b10 && wp, "R9", status, 2);
    recover_from_lock("R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule